// File: doc/BRIEF.md
# Load-Use Register Interlock

This block is the hazard scoreboard for the issue stage of a simple in-order pipeline. Register-to-register instructions finish in two phases: fetch, then an execute phase that reads and writes the register file. Loads take a third phase, in which memory data moves into a register. The block locks the target register of each load from the moment the load issues until the loaded value is written back.

Every cycle the block compares the instruction in the issue slot with the lock vector. If both source fields and the destination field are free of locks, the instruction issues and the memory latency is hidden. If any of them hits a locked register, the block holds the issue stage until the load completes. A completion strobe that names the register in the same cycle counts as forwarded data, so the dependent instruction issues in that cycle. The number of loads in flight is capped, and a load that would exceed the cap is held the same way.

Top module: `ldlk_interlock`

## Requirements
- R1: A load accepted from the issue slot (valid, load flag set, stall low) with destination d not 0 sets bit d of `lock_vec` on the next clock edge. Bit i of `lock_vec` stands for register i.
- R2: A valid instruction whose rs1, rs2 and rd fields all name unlocked registers does not raise `stall`, even while loads are outstanding.
- R3: `stall` is high in the same cycle when a valid instruction has rs1 or rs2 equal to a locked register.
- R4: `stall` is high in the same cycle when a valid instruction has rd equal to a locked register. This covers the write-after-write case.
- R5: A completion strobe for register d clears bit d of `lock_vec` on the next clock edge, unless a new load to d is accepted in the same cycle.
- R6: When a completion for register d arrives in the same cycle, a lock on d does not cause a stall. The data is taken as forwarded.
- R7: Register 0 is never locked. A field that names register 0 never causes a stall.
- R8: While 2 loads are pending (LD_MAX default), a further valid load stalls unless a completion arrives in the same cycle.
- R9: When a load to d is accepted in the same cycle that a completion for d arrives, bit d ends up set.
- R10: An empty issue slot (valid low) never stalls. A stalled load does not change `lock_vec`.
- R11: After reset, `lock_vec` is all zero, no loads are pending, and an empty slot does not stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_valid | input | 1 | Issue slot holds an instruction |
| slot_is_load | input | 1 | Instruction in the slot is a load |
| slot_rs1 | input | 5 | First source register number |
| slot_rs2 | input | 5 | Second source register number |
| slot_rd | input | 5 | Destination register number |
| ldret_valid | input | 1 | Load data returns this cycle |
| ldret_reg | input | 5 | Register written by the returning load |
| stall | output | 1 | Hold the issue slot this cycle |
| lock_vec | output | 32 | Currently locked registers, bit i = register i |

## Verification
The assertions assume that a completion strobe arrives only while at least one load is pending, and that it names a register whose load is still outstanding. A completion that nothing requested would leave the pending count inconsistent. The directed tasks keep their own count of the loads in flight and pulse the return strobe only for loads they issued earlier. The same-cycle cases (completion beside a dependent instruction, beside a new load at the cap, beside a new load to the same register) are therefore always legal combinations.

// File: rtl/ldlk_pkg.sv
package ldlk_pkg;
   localparam int unsigned REG_COUNT = 32;
   localparam int unsigned REG_IDX_W = $clog2(REG_COUNT);
   typedef logic [REG_IDX_W-1:0] reg_idx_t;
endpackage

// File: rtl/ldlk_onehot.sv
module ldlk_onehot #(
   parameter int unsigned N     = 32,
   parameter int unsigned IDX_W = $clog2(N)
) (
   input  logic             en,
   input  logic [IDX_W-1:0] idx,
   output logic [N-1:0]     oh
);
   generate
      if (N < 2) begin : g_bad
         initial $error("ldlk_onehot: N must be at least 2");
      end
      for (genvar i = 0; i < N; i++) begin : g_bit
         assign oh[i] = en && (idx == IDX_W'(i));
      end
   endgenerate
endmodule

// File: rtl/ldlk_lockvec.sv
module ldlk_lockvec #(
   parameter int unsigned N     = 32,
   parameter int unsigned IDX_W = $clog2(N)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             set_en,
   input  logic [IDX_W-1:0] set_idx,
   input  logic             clr_en,
   input  logic [IDX_W-1:0] clr_idx,
   output logic [N-1:0]     lock_q
);
   logic [N-1:0] set_oh;
   logic [N-1:0] clr_oh;

   ldlk_onehot #(.N(N), .IDX_W(IDX_W)) u_set_dec (.en(set_en), .idx(set_idx), .oh(set_oh));
   ldlk_onehot #(.N(N), .IDX_W(IDX_W)) u_clr_dec (.en(clr_en), .idx(clr_idx), .oh(clr_oh));

   generate
      for (genvar i = 0; i < N; i++) begin : g_lock
         always_ff @(posedge clk) begin
            if (!rst_n)          lock_q[i] <= 1'b0;
            else if (set_oh[i])  lock_q[i] <= 1'b1;
            else if (clr_oh[i])  lock_q[i] <= 1'b0;
         end
      end
   endgenerate

   AST_SET_MARKS_REG: assert property (@(posedge clk) disable iff (!rst_n)
      set_en |=> lock_q[$past(set_idx)]);                                    // R1
   AST_CLEAR_FREES_REG: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_en && !(set_en && set_idx == clr_idx)) |=> !lock_q[$past(clr_idx)]); // R5
   AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_en && set_en && set_idx == clr_idx) |=> lock_q[$past(clr_idx)]);  // R9
endmodule

// File: rtl/ldlk_pendcnt.sv
module ldlk_pendcnt #(
   parameter int unsigned MAX   = 2,
   parameter int unsigned CNT_W = $clog2(MAX + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic inc,
   input  logic dec,
   output logic full
);
   logic [CNT_W-1:0] cnt_q;

   generate
      if (MAX < 1) begin : g_bad
         initial $error("ldlk_pendcnt: MAX must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)           cnt_q <= '0;
      else if (inc && !dec) cnt_q <= cnt_q + 1'b1;
      else if (dec && !inc) cnt_q <= cnt_q - 1'b1;
   end

   assign full = (cnt_q == CNT_W'(MAX));

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_W'(MAX));                                                 // R8
   AST_RETURN_HAS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      dec |-> cnt_q != '0);                                                  // R8
   AST_FULL_BLOCKS_INC: assert property (@(posedge clk) disable iff (!rst_n)
      (full && !dec) |-> !inc);                                              // R8
endmodule

// File: rtl/ldlk_interlock.sv
module ldlk_interlock
   import ldlk_pkg::*;
#(
   parameter int unsigned NREG   = REG_COUNT,
   parameter int unsigned LD_MAX = 2,
   localparam int unsigned IDX_W = $clog2(NREG)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             slot_valid,
   input  logic             slot_is_load,
   input  logic [IDX_W-1:0] slot_rs1,
   input  logic [IDX_W-1:0] slot_rs2,
   input  logic [IDX_W-1:0] slot_rd,
   input  logic             ldret_valid,
   input  logic [IDX_W-1:0] ldret_reg,
   output logic             stall,
   output logic [NREG-1:0]  lock_vec
);
   logic hz_rs1, hz_rs2, hz_rd, pend_full, cap_block, ld_accept;

   function automatic logic field_hazard(input logic [IDX_W-1:0] r,
                                         input logic [NREG-1:0]  lk,
                                         input logic             rv,
                                         input logic [IDX_W-1:0] rr);
      return (r != '0) && lk[r] && !(rv && rr == r);
   endfunction

   always_comb begin
      hz_rs1    = field_hazard(slot_rs1, lock_vec, ldret_valid, ldret_reg);
      hz_rs2    = field_hazard(slot_rs2, lock_vec, ldret_valid, ldret_reg);
      hz_rd     = field_hazard(slot_rd,  lock_vec, ldret_valid, ldret_reg);
      cap_block = slot_is_load && pend_full && !ldret_valid;
      stall     = slot_valid && (hz_rs1 || hz_rs2 || hz_rd || cap_block);
      ld_accept = slot_valid && slot_is_load && !stall;
   end

   ldlk_lockvec #(.N(NREG), .IDX_W(IDX_W)) u_lockvec (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_en (ld_accept && slot_rd != '0),
      .set_idx(slot_rd),
      .clr_en (ldret_valid),
      .clr_idx(ldret_reg),
      .lock_q (lock_vec)
   );

   ldlk_pendcnt #(.MAX(LD_MAX)) u_pend (
      .clk  (clk),
      .rst_n(rst_n),
      .inc  (ld_accept),
      .dec  (ldret_valid),
      .full (pend_full)
   );

   AST_R0_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      !lock_vec[0]);                                                         // R7
   AST_SRC_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_valid && slot_rs1 != '0 && lock_vec[slot_rs1] && !ldret_valid) |-> stall); // R3
   AST_DST_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_valid && slot_rd != '0 && lock_vec[slot_rd] && !ldret_valid) |-> stall);   // R4
   AST_EMPTY_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      !slot_valid |-> !stall);                                               // R10
   AST_STALL_KEEPS_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      (stall && !ldret_valid) |=> $stable(lock_vec));                        // R10
endmodule

// File: tb/ldlk_interlock_bench.sv
module ldlk_interlock_bench;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        slot_valid, slot_is_load, ldret_valid;
   logic [4:0]  slot_rs1, slot_rs2, slot_rd, ldret_reg;
   logic        stall;
   logic [31:0] lock_vec;
   int          n_checks = 0;
   int          n_errors = 0;

   always #10 clk = ~clk;

   ldlk_interlock u_ldlk_interlock (
      .clk(clk), .rst_n(rst_n), .slot_valid(slot_valid), .slot_is_load(slot_is_load),
      .slot_rs1(slot_rs1), .slot_rs2(slot_rs2), .slot_rd(slot_rd),
      .ldret_valid(ldret_valid), .ldret_reg(ldret_reg),
      .stall(stall), .lock_vec(lock_vec));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic idle();
      slot_valid = 0; slot_is_load = 0; slot_rs1 = 0; slot_rs2 = 0; slot_rd = 0;
      ldret_valid = 0; ldret_reg = 0;
   endtask

   task automatic put(input logic ld, input logic [4:0] a, input logic [4:0] b, input logic [4:0] d);
      slot_valid = 1; slot_is_load = ld; slot_rs1 = a; slot_rs2 = b; slot_rd = d;
      #2;
   endtask

   task automatic ret(input logic [4:0] r);
      ldret_valid = 1; ldret_reg = r; #2;
   endtask

   task automatic step();
      @(posedge clk); @(negedge clk); idle(); #2;
   endtask

   task automatic t_reset();
      chk("R11 lock", lock_vec, 32'h0);
      chk("R11 stall", {31'b0, stall}, 32'h0);
   endtask

   task automatic t_load_lock();
      put(1, 0, 0, 5);
      chk("R1 load no stall", {31'b0, stall}, 32'h0);
      step();
      chk("R1 lock r5", lock_vec, 32'h20);
   endtask

   task automatic t_independent();
      put(0, 1, 2, 3);
      chk("R2 independent", {31'b0, stall}, 32'h0);
      idle();
   endtask

   task automatic t_dep_src();
      put(0, 5, 2, 3);
      chk("R3 rs1 hazard", {31'b0, stall}, 32'h1);
      put(0, 1, 5, 3);
      chk("R3 rs2 hazard", {31'b0, stall}, 32'h1);
      idle();
   endtask

   task automatic t_dep_dst();
      put(0, 1, 2, 5);
      chk("R4 rd hazard", {31'b0, stall}, 32'h1);
      step();
      chk("R10 lock kept while stalled", lock_vec, 32'h20);
   endtask

   task automatic t_forward();
      put(0, 5, 0, 6);
      ret(5);
      chk("R6 forward", {31'b0, stall}, 32'h0);
      step();
      chk("R5 cleared", lock_vec, 32'h0);
   endtask

   task automatic t_r0();
      put(1, 0, 0, 0);
      step();
      chk("R7 r0 not locked", lock_vec, 32'h0);
      put(0, 0, 0, 0);
      chk("R7 r0 no stall", {31'b0, stall}, 32'h0);
      idle(); ret(0); step();
   endtask

   task automatic t_pend_limit();
      put(1, 0, 0, 6); step();
      put(1, 0, 0, 7); step();
      chk("R1 two locks", lock_vec, 32'hC0);
      put(1, 1, 2, 8);
      chk("R8 third load stalls", {31'b0, stall}, 32'h1);
      step();
      chk("R10 stalled load no lock", lock_vec, 32'hC0);
      put(1, 1, 2, 8); ret(6);
      chk("R8 load with return", {31'b0, stall}, 32'h0);
      step();
      chk("R8 locks after swap", lock_vec, 32'h180);
      ret(7); step();
      ret(8); step();
      chk("R5 all cleared", lock_vec, 32'h0);
   endtask

   task automatic t_set_wins();
      put(1, 0, 0, 9); step();
      put(1, 0, 0, 9); ret(9);
      chk("R9 reload no stall", {31'b0, stall}, 32'h0);
      step();
      chk("R9 set wins", lock_vec, 32'h200);
      ret(9); step();
      chk("R5 r9 cleared", lock_vec, 32'h0);
   endtask

   task automatic t_empty();
      put(1, 0, 0, 4); step();
      slot_valid = 0; slot_rs1 = 4; slot_rd = 4; #2;
      chk("R10 empty slot", {31'b0, stall}, 32'h0);
      idle(); ret(4); step();
      chk("R5 r4 cleared", lock_vec, 32'h0);
   endtask

   initial begin
      #1000000;
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin
      idle();
      rst_n = 0;
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1; #2;
      t_reset();
      t_load_lock();
      t_independent();
      t_dep_src();
      t_dep_dst();
      t_forward();
      t_r0();
      t_pend_limit();
      t_set_wins();
      t_empty();
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end
endmodule